// File: doc/BRIEF.md
# Dual-Domain Set/Clear Flag Registers

This block keeps two 32-bit words of general-purpose flags behind a simple memory-mapped bus. Software never writes a flag word directly. It changes a word by writing a mask. A mask written to the word's own offset turns on every flag whose mask bit is 1. A mask written to the following word offset turns off every flag whose mask bit is 1. Mask bits that are 0 leave their flags alone. Two agents can therefore update disjoint bits without a read-modify-write race.

The two words sit in different reset domains. The volatile word returns to zero on any reset. The persistent word returns to zero only on power-on reset. It keeps its value through a system (soft or manual) reset, so software can leave notes for itself across a restart. Reads are combinational: `bus_rdata` is valid in the same cycle as the read request.

Top module: `flag_pair_regs`

## Requirements
- R1: A read (bus_en=1, bus_we=0) at offset 0x30 returns the volatile flags, and a read at offset 0x38 returns the persistent flags, in the same cycle.
- R2: A full-word write at offset 0x30 sets each volatile flag whose write-data bit is 1; flags whose data bit is 0 keep their value.
- R3: A full-word write at offset 0x34 clears each volatile flag whose write-data bit is 1; flags whose data bit is 0 keep their value.
- R4: Full-word writes at 0x38 (set) and 0x3C (clear) act on the persistent flags in the same way, leaving the volatile flags unchanged.
- R5: bus_rdata is zero for reads of 0x34, 0x3C or any unmapped offset, and whenever no read is requested.
- R6: Asserting sys_rst_n low clears the volatile flags and leaves the persistent flags unchanged; a persistent-word write during system reset still takes effect.
- R7: Asserting por_n low clears both flag words.
- R8: A write whose byte strobes bus_be are not all 1 (4'hF) changes neither flag word.
- R9: A write to any offset other than 0x30, 0x34, 0x38 or 0x3C changes neither flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears both words |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears the volatile word only |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte strobes; a write needs all four |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
A system reset and a bus write can land in the same cycle. The volatile word must then stay at zero, while a persistent-word write must still be captured. The bench holds sys_rst_n low and issues a set write to each word. After the reset is released it reads both words back: the volatile word must be zero, and the persistent word must show the new bits merged with its earlier value.

// File: rtl/flag_pair_regs.sv
module flag_pair_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] VOL_OFS = 8'h30,
  parameter logic [ADDR_W-1:0] NV_OFS  = 8'h38
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int BE_W = DATA_W / 8;
  localparam int LSB  = $clog2(BE_W);
  localparam int WA_W = ADDR_W - LSB;
  localparam logic [WA_W-1:0] VOL_SET = VOL_OFS[ADDR_W-1:LSB];
  localparam logic [WA_W-1:0] VOL_CLR = VOL_SET + 1'b1;
  localparam logic [WA_W-1:0] NV_SET  = NV_OFS[ADDR_W-1:LSB];
  localparam logic [WA_W-1:0] NV_CLR  = NV_SET + 1'b1;

  logic [DATA_W-1:0] vol_q, nv_q;
  logic [WA_W-1:0]   word;
  logic vol_rst_n, wr_ok, rd;
  logic vol_set, vol_clr, nv_set, nv_clr;

  assign vol_rst_n = por_n & sys_rst_n;
  assign word      = bus_addr[ADDR_W-1:LSB];
  assign wr_ok     = bus_en & bus_we & (&bus_be);
  assign rd        = bus_en & ~bus_we;
  assign vol_set   = wr_ok && (word == VOL_SET);
  assign vol_clr   = wr_ok && (word == VOL_CLR);
  assign nv_set    = wr_ok && (word == NV_SET);
  assign nv_clr    = wr_ok && (word == NV_CLR);

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n)   vol_q <= '0;
    else if (vol_set) vol_q <= vol_q | bus_wdata;
    else if (vol_clr) vol_q <= vol_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      nv_q <= '0;
    else if (nv_set) nv_q <= nv_q | bus_wdata;
    else if (nv_clr) nv_q <= nv_q & ~bus_wdata;
  end

  assign bus_rdata = (rd && word == VOL_SET) ? vol_q :
                     (rd && word == NV_SET)  ? nv_q  : '0;

  // R2
  vol_set_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    vol_set |=> ((vol_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  vol_clr_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    vol_clr |=> ((vol_q & $past(bus_wdata)) == '0));
  // R4
  nv_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    nv_clr |=> ((nv_q & $past(bus_wdata)) == '0));
  // R8
  partial_be_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    (bus_en && bus_we && !(&bus_be)) |=> ($stable(vol_q) && $stable(nv_q)));
  // R6
  nv_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(nv_set || nv_clr) |=> $stable(nv_q));
  // R5
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rd |-> (bus_rdata == '0));
  // R7
  always @(posedge clk) begin
    if (!por_n) por_clear_chk: assert (nv_q == '0 && vol_q == '0);
  end
endmodule

// File: tb/tb_flag_pair_regs.sv
module tb_flag_pair_regs;
  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_pair_regs dut (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0,         8'd7}, // R7 reset state
    '{1'b0, 8'h38, 4'hF, 32'h0,         32'h0,         8'd7},
    '{1'b1, 8'h30, 4'hF, 32'h0000_00F0, 32'h0,         8'd2},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_00F0, 8'd2}, // R2
    '{1'b1, 8'h30, 4'hF, 32'h0000_0F00, 32'h0,         8'd2},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FF0, 8'd2},
    '{1'b1, 8'h34, 4'hF, 32'h0000_0030, 32'h0,         8'd3},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FC0, 8'd3}, // R3
    '{1'b1, 8'h34, 4'hF, 32'h0,         32'h0,         8'd3},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FC0, 8'd3},
    '{1'b0, 8'h34, 4'hF, 32'h0,         32'h0,         8'd5}, // R5
    '{1'b1, 8'h38, 4'hF, 32'hA5A5_0000, 32'h0,         8'd4},
    '{1'b0, 8'h38, 4'hF, 32'h0,         32'hA5A5_0000, 8'd4}, // R4
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FC0, 8'd4},
    '{1'b1, 8'h3C, 4'hF, 32'h0505_0000, 32'h0,         8'd4},
    '{1'b0, 8'h38, 4'hF, 32'h0,         32'hA0A0_0000, 8'd4},
    '{1'b0, 8'h3C, 4'hF, 32'h0,         32'h0,         8'd5},
    '{1'b1, 8'h30, 4'h7, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FC0, 8'd8}, // R8
    '{1'b1, 8'h3C, 4'h1, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 8'h38, 4'hF, 32'h0,         32'hA0A0_0000, 8'd8},
    '{1'b1, 8'h2C, 4'hF, 32'hFFFF_FFFF, 32'h0,         8'd9},
    '{1'b1, 8'h40, 4'hF, 32'hFFFF_FFFF, 32'h0,         8'd9},
    '{1'b0, 8'h30, 4'hF, 32'h0,         32'h0000_0FC0, 8'd9}, // R9
    '{1'b0, 8'h38, 4'hF, 32'h0,         32'hA0A0_0000, 8'd9},
    '{1'b0, 8'h40, 4'hF, 32'h0,         32'h0,         8'd5},
    '{1'b0, 8'h3A, 4'hF, 32'h0,         32'hA0A0_0000, 8'd1}  // R1 byte offset in word
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input int req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    #1 check(bus_rdata, exp, req);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    #1 check(bus_rdata, 32'h0, 5); // R5 idle bus
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_wr(VEC[i].addr, VEC[i].be, VEC[i].data);
      else           do_rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
    end
    // R6 system reset: volatile cleared, persistent kept
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    do_rd(8'h30, 32'h0, 6);
    do_rd(8'h38, 32'hA0A0_0000, 6);
    // R6 writes during system reset: only the persistent one lands
    do_wr(8'h30, 4'hF, 32'h0000_0003);
    @(negedge clk); sys_rst_n = 1'b0;
    do_wr(8'h30, 4'hF, 32'h0000_0100);
    do_wr(8'h38, 4'hF, 32'h0000_0001);
    @(negedge clk); sys_rst_n = 1'b1;
    do_rd(8'h30, 32'h0, 6);
    do_rd(8'h38, 32'hA0A0_0001, 6);
    // R7 power-on reset clears both
    do_wr(8'h30, 4'hF, 32'h8000_0001);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    do_rd(8'h30, 32'h0, 7);
    do_rd(8'h38, 32'h0, 7);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule